// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a small multicycle processor for a 16-bit, word-addressed instruction set. It has eight general registers and sixteen opcodes selected by the top four bits of the instruction word. It spends one memory access fetching each instruction and bumps the program counter as soon as that word arrives. In the following cycle it decodes and executes register operations, branches and jumps directly. Loads, stores, indirect accesses and trap dispatch need one or two more memory accesses.

All traffic goes through a single word-wide port. The core raises a request with an address, a write strobe and write data, and holds all of them steady until the memory answers with a one-cycle valid pulse. Only one access is ever in flight. A read's data arrives together with that pulse. The two opcodes the core does not implement (privileged return, value 8, and the reserved value 13) stop it for good: it raises an illegal-opcode flag and a halted output, and only reset brings it back.

Top module: `cpu16_core`

## Requirements
- R1: During and after reset the core is not halted and shows no illegal opcode. Its first request is a read at address 0x3000. All registers reset to zero and the condition code resets to "zero" (Z set, N and P clear).
- R2: Each instruction begins with a read at the program counter. The counter is incremented by one as soon as that read completes, so every later offset is relative to the incremented value. The opcode is bits [15:12], with 0=branch, 1=add, 2=load, 3=store, 4=subroutine call, 5=and, 6=load-base, 7=store-base, 8=privileged return, 9=not, 10=load-indirect, 11=store-indirect, 12=jump, 13=reserved, 14=load-address, 15=trap.
- R3: Add and and write register [11:9] with register [8:6] combined with a second operand. When bit 5 is 0 the second operand is register [2:0]. When bit 5 is 1 it is bits [4:0] sign-extended.
- R4: Not writes the bitwise complement of register [8:6] into register [11:9].
- R5: Load, store and load-address use as their address the incremented PC plus bits [8:0] sign-extended, wrapping modulo 2^16. Load writes the word read into register [11:9], store writes register [11:9] to memory, and load-address writes the address itself into register [11:9].
- R6: Load-base and store-base use register [8:6] plus bits [5:0] sign-extended as their address, wrapping modulo 2^16.
- R7: Load-indirect and store-indirect first read a pointer at the PC-relative address. A second access then reads the word at that pointer, or writes register [11:9] to it.
- R8: Add, and, not, all three loads and load-address set the condition code from the value written: N if bit 15 is 1, Z if the value is zero, P otherwise. No other opcode changes it. A branch adds sign-extended bits [8:0] to the PC when any of bits 11 (N), 10 (Z) and 9 (P) is set while the matching flag is set.
- R9: A subroutine call writes the incremented PC to register 7. With bit 11 = 1 it then adds sign-extended bits [10:0] to the PC; with bit 11 = 0 it jumps to register [8:6], read before the link write. Jump loads the PC from register [8:6].
- R10: A trap writes the incremented PC to register 7, reads the word at address zero-extended bits [7:0], and continues at that word.
- R11: Opcodes 8 and 13 set the illegal-opcode flag and the halted output. Both stay set, and no further request is made until reset.
- R12: A request keeps its address, write strobe and write data unchanged until the cycle in which valid is seen. Only one access is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Memory access requested |
| memWe | output | 1 | Requested access is a write |
| memAddr | output | 16 | Word address of the access |
| memWdata | output | 16 | Data for a write access |
| memValid | input | 1 | One-cycle pulse: access complete |
| memRdata | input | 16 | Read data, valid with memValid |
| halted | output | 1 | Core stopped until reset |
| illegalOp | output | 1 | An unimplemented opcode was decoded |

## Verification
Every internal state of this core shows up at the memory port, because each instruction starts with a fetch whose address is the program counter. Here is how each kind of fault surfaces:
- A wrong PC update, a wrong branch decision or a wrong condition code changes the address of the next fetch, one or two accesses later.
- A wrong register value shows at the latest when that register is stored, used as a base or used as a jump target.
- A sequencing fault in the indirect or trap paths changes how many accesses an instruction makes and what kind they are.

The bench therefore compares every access, in order, against an instruction-level model, and programs end by storing values and then reaching an unimplemented opcode.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int RIDX = $clog2(NREG);
  localparam int LINK_REG = NREG - 1;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_BR = 4'd0, OP_ADD = 4'd1, OP_LD = 4'd2, OP_ST = 4'd3,
    OP_JSR = 4'd4, OP_AND = 4'd5, OP_LDR = 4'd6, OP_STR = 4'd7,
    OP_RTI = 4'd8, OP_NOT = 4'd9, OP_LDI = 4'd10, OP_STI = 4'd11,
    OP_JMP = 4'd12, OP_RSV = 4'd13, OP_LEA = 4'd14, OP_TRAP = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {PCS_OFF9, PCS_OFF11, PCS_BASE, PCS_MEM} pc_src_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC} wb_src_e;
  typedef enum logic [1:0] {AS_EA, AS_MEM, AS_VEC} addr_src_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_PTR, S_RD, S_WR, S_VEC, S_HALT
  } state_e;

  // Strobes from the control FSM to the datapath for one cycle.
  typedef struct packed {
    logic      irLoad;
    logic      pcInc;
    logic      pcLoad;
    pc_src_e   pcSrc;
    logic      regWe;
    wb_src_e   wbSrc;
    logic      wbLink;
    logic      ccLoad;
    logic      addrLoad;
    addr_src_e addrSrc;
    logic      useAddr;
  } ctl_t;

  // Sign-extend the low 'bits' bits of v to XLEN.
  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] v, input int bits);
    logic signed [XLEN-1:0] t;
    t = $signed(v << (XLEN - bits));
    return t >>> (XLEN - bits);
  endfunction
endpackage

// File: rtl/cpu16_ccu.sv
module cpu16_ccu
  import cpu16_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            load,
  input  logic [XLEN-1:0] value,
  input  logic [2:0]      brMask,
  output logic            taken
);
  logic [2:0] nzp;

  always_ff @(posedge clk) begin
    if (!rstN) nzp <= 3'b010;
    else if (load) begin
      if (value[XLEN-1]) nzp <= 3'b100;
      else if (value == '0) nzp <= 3'b010;
      else nzp <= 3'b001;
    end
  end

  assign taken = |(brMask & nzp);
endmodule

// File: rtl/cpu16_datapath.sv
module cpu16_datapath
  import cpu16_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_t            ctl,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output opcode_e         op,
  output logic            jsrRel,
  output logic            brTaken
);
  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] ir, pc, addrReg;
  logic [RIDX-1:0] dr, sr1, sr2, wIdx;
  logic [XLEN-1:0] srcA, srcB, aluOut, ea, wbData, off9;

  assign op     = opcode_e'(ir[XLEN-1 -: OPW]);
  assign jsrRel = ir[11];
  assign dr     = ir[11:9];
  assign sr1    = ir[8:6];
  assign sr2    = ir[2:0];
  assign off9   = sext(ir, 9);

  assign srcA = regs[sr1];
  assign srcB = ir[5] ? sext(ir, 5) : regs[sr2];

  always_comb begin
    case (op)
      OP_AND:  aluOut = srcA & srcB;
      OP_NOT:  aluOut = ~srcA;
      OP_LEA:  aluOut = pc + off9;
      default: aluOut = srcA + srcB;
    endcase
  end

  assign ea = (op == OP_LDR || op == OP_STR) ? srcA + sext(ir, 6) : pc + off9;

  always_comb begin
    case (ctl.wbSrc)
      WB_MEM:  wbData = memRdata;
      WB_PC:   wbData = pc;
      default: wbData = aluOut;
    endcase
  end

  assign wIdx = ctl.wbLink ? RIDX'(LINK_REG) : dr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctl.regWe) begin
      regs[wIdx] <= wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ir <= '0;
    else if (ctl.irLoad) ir <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pc <= RESET_PC;
    else if (ctl.pcInc) pc <= pc + 1'b1;
    else if (ctl.pcLoad) begin
      case (ctl.pcSrc)
        PCS_OFF9:  pc <= pc + off9;
        PCS_OFF11: pc <= pc + sext(ir, 11);
        PCS_BASE:  pc <= srcA;
        default:   pc <= memRdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) addrReg <= '0;
    else if (ctl.addrLoad) begin
      case (ctl.addrSrc)
        AS_MEM:  addrReg <= memRdata;
        AS_VEC:  addrReg <= {{(XLEN-8){1'b0}}, ir[7:0]};
        default: addrReg <= ea;
      endcase
    end
  end

  assign memAddr  = ctl.useAddr ? addrReg : pc;
  assign memWdata = regs[dr];

  cpu16_ccu u_ccu (
    .clk    (clk),
    .rstN   (rstN),
    .load   (ctl.ccLoad),
    .value  (wbData),
    .brMask (ir[11:9]),
    .taken  (brTaken)
  );
endmodule

// File: rtl/cpu16_control.sv
module cpu16_control
  import cpu16_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  opcode_e op,
  input  logic    jsrRel,
  input  logic    brTaken,
  input  logic    memValid,
  output ctl_t    ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    halted,
  output logic    illegalOp
);
  state_e state, nextState;
  logic   illegalQ;

  always_comb begin
    ctl       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      S_FETCH: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.irLoad = 1'b1;
          ctl.pcInc  = 1'b1;
          nextState  = S_DECODE;
        end
      end
      S_DECODE: begin
        nextState = S_FETCH;
        case (op)
          OP_BR: if (brTaken) begin
            ctl.pcLoad = 1'b1;
            ctl.pcSrc  = PCS_OFF9;
          end
          OP_ADD, OP_AND, OP_NOT, OP_LEA: begin
            ctl.regWe  = 1'b1;
            ctl.wbSrc  = WB_ALU;
            ctl.ccLoad = 1'b1;
          end
          OP_LD, OP_LDR: begin
            ctl.addrLoad = 1'b1;
            nextState    = S_RD;
          end
          OP_LDI, OP_STI: begin
            ctl.addrLoad = 1'b1;
            nextState    = S_PTR;
          end
          OP_ST, OP_STR: begin
            ctl.addrLoad = 1'b1;
            nextState    = S_WR;
          end
          OP_JSR: begin
            ctl.regWe  = 1'b1;
            ctl.wbLink = 1'b1;
            ctl.wbSrc  = WB_PC;
            ctl.pcLoad = 1'b1;
            ctl.pcSrc  = jsrRel ? PCS_OFF11 : PCS_BASE;
          end
          OP_JMP: begin
            ctl.pcLoad = 1'b1;
            ctl.pcSrc  = PCS_BASE;
          end
          OP_TRAP: begin
            ctl.regWe    = 1'b1;
            ctl.wbLink   = 1'b1;
            ctl.wbSrc    = WB_PC;
            ctl.addrLoad = 1'b1;
            ctl.addrSrc  = AS_VEC;
            nextState    = S_VEC;
          end
          default: nextState = S_HALT;
        endcase
      end
      S_PTR: begin
        memReq      = 1'b1;
        ctl.useAddr = 1'b1;
        if (memValid) begin
          ctl.addrLoad = 1'b1;
          ctl.addrSrc  = AS_MEM;
          nextState    = (op == OP_LDI) ? S_RD : S_WR;
        end
      end
      S_RD: begin
        memReq      = 1'b1;
        ctl.useAddr = 1'b1;
        if (memValid) begin
          ctl.regWe  = 1'b1;
          ctl.wbSrc  = WB_MEM;
          ctl.ccLoad = 1'b1;
          nextState  = S_FETCH;
        end
      end
      S_WR: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.useAddr = 1'b1;
        if (memValid) nextState = S_FETCH;
      end
      S_VEC: begin
        memReq      = 1'b1;
        ctl.useAddr = 1'b1;
        if (memValid) begin
          ctl.pcLoad = 1'b1;
          ctl.pcSrc  = PCS_MEM;
          nextState  = S_FETCH;
        end
      end
      default: nextState = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_FETCH;
      illegalQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_DECODE && nextState == S_HALT) illegalQ <= 1'b1;
    end
  end

  assign halted    = (state == S_HALT);
  assign illegalOp = illegalQ;
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
  input  logic            clk,
  input  logic            rstN,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic            memValid,
  input  logic [XLEN-1:0] memRdata,
  output logic            halted,
  output logic            illegalOp
);
  ctl_t    ctl;
  opcode_e op;
  logic    jsrRel, brTaken;

  cpu16_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .op        (op),
    .jsrRel    (jsrRel),
    .brTaken   (brTaken),
    .memValid  (memValid),
    .ctl       (ctl),
    .memReq    (memReq),
    .memWe     (memWe),
    .halted    (halted),
    .illegalOp (illegalOp)
  );

  cpu16_datapath #(.RESET_PC(RESET_PC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .op       (op),
    .jsrRel   (jsrRel),
    .brTaken  (brTaken)
  );
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk #(
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWe,
  input logic [15:0] memAddr,
  input logic [15:0] memWdata,
  input logic        memValid,
  input logic        halted,
  input logic        illegalOp
);
  logic seenReq;

  always_ff @(posedge clk) begin
    if (!rstN) seenReq <= 1'b0;
    else if (memReq) seenReq <= 1'b1;
  end

  // R1: first access after reset is the fetch at the reset address
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !seenReq) |-> (memAddr == RESET_PC && !memWe));

  // R12: an unanswered request stays put
  p_hold_request_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R12: a write strobe never appears without a request
  p_write_needs_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R11: a halted core is silent
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memReq);

  // R11: the illegal flag and the halt stay until reset
  p_illegal_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> (illegalOp && halted));
endmodule

bind cpu16_core cpu16_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .memValid  (memValid),
  .halted    (halted),
  .illegalOp (illegalOp)
);

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq, memWe, memValid = 1'b0, halted, illegalOp;
  logic [15:0] memAddr, memWdata, memRdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  cpu16_core u0 (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memValid(memValid), .memRdata(memRdata),
    .halted(halted), .illegalOp(illegalOp)
  );

  int tests = 0, fails = 0, cycles = 0;

  logic [15:0] dmem [int];
  logic [15:0] rmem [int];

  typedef struct packed { logic we; logic [15:0] a; logic [15:0] d; } acc_t;
  acc_t expQ[$];

  logic [15:0] rR [8];
  logic [15:0] rPc;
  logic [2:0]  rCc;
  bit          rHalt;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side model of the instruction set
  function automatic logic [15:0] sx(input logic [15:0] v, input int b);
    logic [15:0] m, low;
    m   = 16'h1 << (b - 1);
    low = v & ((16'h1 << b) - 16'h1);
    return (low ^ m) - m;
  endfunction

  function automatic logic [15:0] refRd(input logic [15:0] a);
    expQ.push_back(acc_t'{we: 1'b0, a: a, d: 16'h0});
    return rmem.exists(int'(a)) ? rmem[int'(a)] : 16'hD000;
  endfunction

  function automatic void refWr(input logic [15:0] a, input logic [15:0] d);
    expQ.push_back(acc_t'{we: 1'b1, a: a, d: d});
    rmem[int'(a)] = d;
  endfunction

  function automatic void refSet(input logic [2:0] r, input logic [15:0] v);
    rR[r] = v;
    rCc = v[15] ? 3'b100 : (v == 16'h0) ? 3'b010 : 3'b001;
  endfunction

  function automatic void refStep();
    logic [15:0] ir, p, t;
    logic [2:0]  d, s;
    if (rHalt) return;
    ir  = refRd(rPc);
    rPc = rPc + 16'h1;
    d = ir[11:9];
    s = ir[8:6];
    case (ir[15:12])
      4'd0:  if (|(ir[11:9] & rCc)) rPc = rPc + sx(ir, 9);
      4'd1:  refSet(d, rR[s] + (ir[5] ? sx(ir, 5) : rR[ir[2:0]]));
      4'd5:  refSet(d, rR[s] & (ir[5] ? sx(ir, 5) : rR[ir[2:0]]));
      4'd9:  refSet(d, ~rR[s]);
      4'd2:  refSet(d, refRd(rPc + sx(ir, 9)));
      4'd6:  refSet(d, refRd(rR[s] + sx(ir, 6)));
      4'd10: begin p = refRd(rPc + sx(ir, 9)); refSet(d, refRd(p)); end
      4'd3:  refWr(rPc + sx(ir, 9), rR[d]);
      4'd7:  refWr(rR[s] + sx(ir, 6), rR[d]);
      4'd11: begin p = refRd(rPc + sx(ir, 9)); refWr(p, rR[d]); end
      4'd14: refSet(d, rPc + sx(ir, 9));
      4'd4:  begin
        t = ir[11] ? rPc + sx(ir, 11) : rR[s];
        rR[7] = rPc;
        rPc = t;
      end
      4'd12: rPc = rR[s];
      4'd15: begin rR[7] = rPc; rPc = refRd({8'h00, ir[7:0]}); end
      default: rHalt = 1'b1;
    endcase
  endfunction

  function automatic void refReset();
    for (int i = 0; i < 8; i++) rR[i] = 16'h0;
    rPc = 16'h3000;
    rCc = 3'b010;
    rHalt = 1'b0;
    expQ.delete();
    rmem = dmem;
  endfunction

  // Reset, then serve the memory port and compare every access to the model
  task automatic runProg(input string tag, input int maxAcc);
    int n = 0, idle = 0;
    acc_t e;
    logic [15:0] a, d;
    logic w;
    @(negedge clk);
    rstN = 1'b0;
    memValid = 1'b0;
    refReset();
    repeat (3) @(negedge clk);
    chk(halted == 1'b0 && illegalOp == 1'b0, "R1 reset state", {14'h0, halted, illegalOp}, 16'h0);
    rstN = 1'b1;
    while (n < maxAcc && idle < 30) begin
      @(negedge clk);
      if (memReq) begin
        idle = 0;
        a = memAddr; w = memWe; d = memWdata;
        if (expQ.size() == 0) refStep();
        if (expQ.size() == 0) begin
          chk(1'b0, {tag, " R11 access after halt"}, a, 16'h0);
        end else begin
          e = expQ.pop_front();
          chk(e.a == a && e.we == w && (!w || e.d == d), {tag, " R2 R12 access trace"},
              w ? d : a, e.we ? e.d : e.a);
          if (e.a != a || e.we != w) chk(1'b0, {tag, " R12 kind"}, {15'h0, w}, {15'h0, e.we});
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (w) dmem[int'(a)] = d;
        else memRdata = dmem.exists(int'(a)) ? dmem[int'(a)] : 16'hD000;
        memValid = 1'b1;
        @(negedge clk);
        memValid = 1'b0;
        n++;
      end else begin
        idle++;
      end
    end
    if (n < maxAcc) begin
      if (expQ.size() == 0 && !rHalt) refStep();
      chk(rHalt && expQ.size() == 0, {tag, " R11 model halt agrees"}, 16'(expQ.size()), 16'h0);
      chk(halted == 1'b1, {tag, " R11 halted"}, {15'h0, halted}, 16'h1);
      chk(illegalOp == 1'b1, {tag, " R11 illegalOp"}, {15'h0, illegalOp}, 16'h1);
    end
  endtask

  task automatic loadProg(input logic [15:0] base, input logic [15:0] w [$]);
    dmem.delete();
    foreach (w[i]) dmem[int'(base) + i] = w[i];
  endtask

  initial begin
    logic [15:0] p [$];
    void'($urandom(32'd20240611));

    // ALU, branch, PC-relative, base, call, indirect, jump; ends on opcode 13
    p = '{16'h127F, 16'h5465, 16'h96BF, 16'h1842, 16'h0401, 16'h0201, 16'hD000,
          16'h3608, 16'hEBF8, 16'h7B7F, 16'h4802, 16'hD000, 16'hD000, 16'hBE02,
          16'hAC01, 16'hC180, 16'h0000};
    loadProg(16'h3000, p);
    runProg("R3 R4 R5 R6 R7 R8 R9", 400);

    // Trap dispatch, register-form call via R7, loads; ends on opcode 8
    p = '{16'hF030, 16'h61FF, 16'h23FD, 16'h8000};
    loadProg(16'h3000, p);
    dmem[32'h0030] = 16'h3100;
    dmem[32'h3100] = 16'h41C0;
    runProg("R10 R9 R6 R5 R11", 400);

    // Base address wrapping through 0xFFFF to 0x0000
    p = '{16'h127F, 16'h7241, 16'h6441, 16'h16A1, 16'h0BFF, 16'hD000};
    loadProg(16'h3000, p);
    runProg("R6 R8 wrap", 400);

    // Random programs
    for (int t = 0; t < 30; t++) begin
      logic [3:0] o;
      p.delete();
      for (int i = 0; i < 48; i++) begin
        o = 4'($urandom_range(0, 15));
        if (o == 4'd8 || o == 4'd13) o = 4'd1;
        p.push_back({o, 12'($urandom())});
      end
      loadProg(16'h3000, p);
      for (int i = 0; i < 8; i++) dmem[32'h3080 + i] = 16'($urandom());
      dmem[int'($urandom_range(0, 255))] = 16'h3000 + 16'($urandom_range(0, 47));
      runProg("random R2 R3 R5 R6 R7 R8 R9 R10 R12", 600);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule